// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns one PWM reference into a complementary pair of outputs with a programmable gap between them. When the reference rises, the primary output waits out the gap before it goes high. When the reference falls, the secondary output does the same. Because of the gap, the two outputs never drive a power stage at the same moment. The gap length comes from an 8-bit code. The code is decoded in four ranges: short delays take single-clock steps and long delays take coarse steps of 2, 8 or 16 clocks. A down-counter paced by a prescaler counts the gap out.

Beside the timing path, the block takes a main enable, a separate enable for each output, two off-state selects (one for run, one for idle) and an idle level for each output. From these it decides, for each output, whether the pin carries the timed waveform, the inactive level or its idle level, or is not driven at all. A pin's drive enable always turns on one clock after the level it carries is valid, so the pin never drives an undefined value.

Top module: `cdt_pair`

## Requirements
- R1: With `dt_code_i[7]` = 0, the dead time DT in clocks equals `dt_code_i[6:0]`.
- R2: With `dt_code_i[7:6]` = 2'b10, DT = (64 + `dt_code_i[5:0]`) × 2.
- R3: With `dt_code_i[7:5]` = 3'b110, DT = (32 + `dt_code_i[4:0]`) × 8.
- R4: With `dt_code_i[7:5]` = 3'b111, DT = (32 + `dt_code_i[4:0]`) × 16.
- R5: In complementary run (`main_en_i`, `p_en_i` and `n_en_i` all 1), a rising reference sampled at clock edge k drives `n_o` low after edge k, and `p_o` goes high after edge k+DT+1.
- R6: In complementary run, a falling reference sampled at edge k drives `p_o` low after edge k, and `n_o` goes high after edge k+DT+1.
- R7: In complementary run, `p_o` and `n_o` are never both 1.
- R8: A reference pulse that is shorter than the dead time produces no pulse on the delayed output.
- R9: In run mode (`main_en_i` = 1), an output whose own enable is 0 is held at 0. Its drive enable is 1 when `safe_run_i` = 1 and 0 when `safe_run_i` = 0.
- R10: With `main_en_i` = 0, an enabled output carries its idle level and is driven when `safe_idle_i` = 1. When `safe_idle_i` = 0, or when the output is not enabled, it is 0 and undriven.
- R11: A drive enable rises one clock after its drive condition appears, and the level is already valid in that clock. A drive enable falls in the same cycle that its condition goes away.
- R12: Clearing `main_en_i` moves both outputs to their idle behaviour in the same cycle and aborts any dead-time count. When `main_en_i` is set again, the active output follows the reference after one clock.
- R13: In run mode with only one output enabled, that output follows the reference delayed by one clock, with no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is one dead-time tick |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | PWM reference |
| dt_code_i | input | 8 | Dead-time code |
| main_en_i | input | 1 | Main output enable (1 = run, 0 = idle) |
| p_en_i | input | 1 | Primary output enable |
| n_en_i | input | 1 | Secondary output enable |
| safe_run_i | input | 1 | Drive disabled outputs inactive in run mode |
| safe_idle_i | input | 1 | Drive enabled outputs at idle level in idle mode |
| p_idle_i | input | 1 | Primary idle level |
| n_idle_i | input | 1 | Secondary idle level |
| p_o | output | 1 | Primary output level |
| n_o | output | 1 | Secondary output level |
| p_oe_o | output | 1 | Primary drive enable |
| n_oe_o | output | 1 | Secondary drive enable |

## Verification
Two events can land on the same edge: the main enable can drop while a dead-time count is still running, or a new reference edge can arrive while a count is in flight. The bench provokes the first case by removing the main enable partway through a 1008-clock count. It then checks that the idle levels appear in that same cycle, and that after re-enable the primary output rises after a single clock instead of finishing the old count. It provokes the second case by sending a pulse shorter than the dead time. The reload must win, so the primary output must stay low for the whole window while the secondary output reappears DT+1 clocks after the second edge.

// File: rtl/cdt_pair.sv
module cdt_pair #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 7,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_i,
  input  logic [CODE_W-1:0] dt_code_i,
  input  logic              main_en_i,
  input  logic              p_en_i,
  input  logic              n_en_i,
  input  logic              safe_run_i,
  input  logic              safe_idle_i,
  input  logic              p_idle_i,
  input  logic              n_idle_i,
  output logic              p_o,
  output logic              n_o,
  output logic              p_oe_o,
  output logic              n_oe_o
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [PRE_W-1:0] PRE_ZERO = '0;

  logic [CNT_W-1:0] base;
  logic [PRE_W-1:0] div_m1;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic             ref_q, p_dt, n_dt;
  logic             p_want, n_want, p_arm, n_arm;
  logic             ref_edge;

  always_comb begin
    casez (dt_code_i[7:5])
      3'b0??: begin base = dt_code_i[6:0];          div_m1 = PRE_W'(0);  end
      3'b10?: begin base = {1'b1, dt_code_i[5:0]};  div_m1 = PRE_W'(1);  end
      3'b110: begin base = {2'b01, dt_code_i[4:0]}; div_m1 = PRE_W'(7);  end
      default: begin base = {2'b01, dt_code_i[4:0]}; div_m1 = PRE_W'(15); end
    endcase
  end

  assign ref_edge = ref_i ^ ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      cnt   <= CNT_ZERO;
      pre   <= PRE_ZERO;
      p_dt  <= 1'b0;
      n_dt  <= 1'b0;
    end else begin
      ref_q <= ref_i;
      if (!main_en_i) begin
        cnt  <= CNT_ZERO;
        pre  <= PRE_ZERO;
        p_dt <= 1'b0;
        n_dt <= 1'b0;
      end else if (ref_edge) begin
        cnt  <= base;
        pre  <= div_m1;
        p_dt <= 1'b0;
        n_dt <= 1'b0;
      end else if (cnt != CNT_ZERO) begin
        if (pre == PRE_ZERO) begin
          pre <= div_m1;
          cnt <= cnt - CNT_W'(1);
        end else begin
          pre <= pre - PRE_W'(1);
        end
      end else begin
        p_dt <= ref_q;
        n_dt <= ~ref_q;
      end
    end
  end

  always_comb begin
    if (main_en_i) begin
      if (p_en_i && n_en_i) begin
        p_o = p_dt; n_o = n_dt; p_want = 1'b1; n_want = 1'b1;
      end else begin
        p_o    = p_en_i & ref_q;
        n_o    = n_en_i & ref_q;
        p_want = p_en_i | safe_run_i;
        n_want = n_en_i | safe_run_i;
      end
    end else begin
      p_want = p_en_i & safe_idle_i;
      n_want = n_en_i & safe_idle_i;
      p_o    = p_want & p_idle_i;
      n_o    = n_want & n_idle_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_arm <= 1'b0;
      n_arm <= 1'b0;
    end else begin
      p_arm <= p_want;
      n_arm <= n_want;
    end
  end

  assign p_oe_o = p_want & p_arm;
  assign n_oe_o = n_want & n_arm;

endmodule

module cdt_pair_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_i,
  input logic             ref_q,
  input logic [CNT_W-1:0] cnt,
  input logic             main_en_i,
  input logic             p_en_i,
  input logic             n_en_i,
  input logic             p_o,
  input logic             n_o
);

  a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en_i && p_en_i && n_en_i) |-> !(p_o && n_o));

  a_r12_count_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en_i |=> (cnt == '0));

  a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en_i && (ref_i == ref_q) && (cnt != '0)) |=> (cnt <= $past(cnt)));

  a_r8_rise_tracks_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en_i && $past(main_en_i) && p_en_i && n_en_i && $past(p_en_i && n_en_i)
     && $rose(p_o)) |-> ref_q);

endmodule

bind cdt_pair cdt_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .ref_q(ref_q), .cnt(cnt),
  .main_en_i(main_en_i), .p_en_i(p_en_i), .n_en_i(n_en_i),
  .p_o(p_o), .n_o(n_o)
);

// File: tb/test_cdt_pair.sv
module test_cdt_pair;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0;
  logic [7:0] dt_code_i = 8'h00;
  logic main_en_i = 1'b0, p_en_i = 1'b0, n_en_i = 1'b0;
  logic safe_run_i = 1'b0, safe_idle_i = 1'b0, p_idle_i = 1'b0, n_idle_i = 1'b0;
  logic p_o, n_o, p_oe_o, n_oe_o;
  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  cdt_pair i_cdt_pair (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dt_code_i(dt_code_i),
    .main_en_i(main_en_i), .p_en_i(p_en_i), .n_en_i(n_en_i),
    .safe_run_i(safe_run_i), .safe_idle_i(safe_idle_i),
    .p_idle_i(p_idle_i), .n_idle_i(n_idle_i),
    .p_o(p_o), .n_o(n_o), .p_oe_o(p_oe_o), .n_oe_o(n_oe_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dt(input logic [7:0] c);
    if (!c[7])          return int'(c[6:0]);
    else if (!c[6])     return (64 + int'(c[5:0])) * 2;
    else if (!c[5])     return (32 + int'(c[4:0])) * 8;
    else                return (32 + int'(c[4:0])) * 16;
  endfunction

  task automatic settle(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 reset p_o", p_o, 0);
    chk("R10 reset n_o", n_o, 0);
    chk("R10 reset p_oe", p_oe_o, 0);
    chk("R10 reset n_oe", n_oe_o, 0);
  endtask

  task automatic t_edge(input logic [7:0] code, input string tag);
    int dt;
    dt = exp_dt(code);
    @(negedge clk);
    dt_code_i = code; main_en_i = 1; p_en_i = 1; n_en_i = 1; ref_i = 0;
    settle(dt + 4);
    chk({tag, " R6 n settled high"}, n_o, 1);
    ref_i = 1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R5 n low after edge"}, n_o, 0);
    if (dt > 0) begin
      settle(dt);
      chk({tag, " R5 p still low at DT"}, p_o, 0);
    end
    @(negedge clk);
    chk({tag, " R5 p high at DT+1"}, p_o, 1);
    chk({tag, " R7 n low"}, n_o, 0);
    settle(dt + 2);
    ref_i = 0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R6 p low after edge"}, p_o, 0);
    if (dt > 0) begin
      settle(dt);
      chk({tag, " R6 n still low at DT"}, n_o, 0);
    end
    @(negedge clk);
    chk({tag, " R6 n high at DT+1"}, n_o, 1);
  endtask

  task automatic t_short_pulse;
    int seen;
    seen = 0;
    @(negedge clk);
    dt_code_i = 8'h10; main_en_i = 1; p_en_i = 1; n_en_i = 1; ref_i = 0;
    settle(20);
    ref_i = 1;
    settle(5);
    ref_i = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (p_o) seen++;
      if (j == 16) chk("R8 n low at DT", n_o, 0);
      if (j == 17) chk("R8 n back at DT+1", n_o, 1);
    end
    chk("R8 no p pulse", seen, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    main_en_i = 0; p_en_i = 0; n_en_i = 0; safe_idle_i = 0; safe_run_i = 0;
    settle(2);
    chk("R10 disabled undriven", p_oe_o, 0);
    p_en_i = 1; n_en_i = 1; safe_idle_i = 1; p_idle_i = 1; n_idle_i = 0;
    #1;
    chk("R11 p level valid first", p_o, 1);
    chk("R11 p_oe not yet", p_oe_o, 0);
    @(negedge clk);
    chk("R10 p_oe on", p_oe_o, 1);
    chk("R10 n_oe on", n_oe_o, 1);
    chk("R10 n idle level", n_o, 0);
    safe_idle_i = 0;
    #1;
    chk("R11 p_oe drops same cycle", p_oe_o, 0);
    chk("R10 p level 0 when undriven", p_o, 0);
  endtask

  task automatic t_run_off;
    @(negedge clk);
    main_en_i = 1; p_en_i = 1; n_en_i = 0; safe_run_i = 1; ref_i = 1;
    settle(2);
    chk("R9 n inactive", n_o, 0);
    chk("R9 n driven", n_oe_o, 1);
    chk("R13 p follows ref", p_o, 1);
    ref_i = 0;
    #1;
    chk("R13 p one clock late", p_o, 1);
    @(negedge clk);
    chk("R13 p follows low", p_o, 0);
    safe_run_i = 0;
    #1;
    chk("R9 n undriven", n_oe_o, 0);
    chk("R9 p driven", p_oe_o, 1);
    p_en_i = 0; n_en_i = 1; ref_i = 1;
    settle(2);
    chk("R13 n follows ref", n_o, 1);
    chk("R9 p held 0", p_o, 0);
  endtask

  task automatic t_abort;
    @(negedge clk);
    dt_code_i = 8'hFF; main_en_i = 1; p_en_i = 1; n_en_i = 1; ref_i = 0;
    safe_idle_i = 1; p_idle_i = 0; n_idle_i = 1;
    settle(1015);
    ref_i = 1;
    settle(10);
    chk("R12 p still in dead time", p_o, 0);
    main_en_i = 0;
    #1;
    chk("R12 p idle same cycle", p_o, 0);
    chk("R12 n idle same cycle", n_o, 1);
    settle(2);
    main_en_i = 1;
    #1;
    chk("R12 p low on re-enable", p_o, 0);
    @(negedge clk);
    chk("R12 p high one clock later", p_o, 1);
    chk("R12 n low", n_o, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1;
    settle(2);
    t_reset();
    t_edge(8'h00, "R1 code00");
    t_edge(8'h25, "R1 code25");
    t_edge(8'h7F, "R1 code7F");
    t_edge(8'h83, "R2 code83");
    t_edge(8'hC5, "R3 codeC5");
    t_edge(8'hE0, "R4 codeE0");
    t_edge(8'hFF, "R4 codeFF");
    t_short_pulse();
    t_idle();
    t_run_off();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule